// File: doc/BRIEF.md
# Predicated Vector Reduction Sequencer

This block folds the active elements of a short integer vector into a single scalar. Software supplies the vector length, a predicate mask and an operation. The sequencer walks the active elements one per cycle, from the lowest index to the highest. It reads them from an external element array and keeps a running accumulator. When the walk ends, it writes the result back into the lowest-indexed active slot. Only operations that give the same answer in any order are accepted: add, multiply, signed minimum, signed maximum and bitwise OR. Any other operation code is refused without touching any state.

The sequencer can also keep a cumulative condition field. Each partial result is classified as negative, positive or zero. These classifications are merged either as "at least one step met the test" (OR) or as "every step met the test" (AND). The merged field is written out next to the scalar result. An element-offset register records the index most recently consumed, so an interrupted reduction can be resumed from saved state.

There is no data stream at the block's edge, so the interface has no valid/ready pairs. The element array answers a read in the same cycle through `rd_data`, and the array's write side always accepts. Control pins are plain level or pulse signals, and nothing can apply back-pressure. A `start` pulse is taken only while the sequencer is idle.

Top module: `red_seq`

## Requirements
- R1: Operation codes 0 add, 1 multiply (low DW bits kept), 2 signed minimum, 3 signed maximum and 4 bitwise OR fold the active elements serially, lowest index first, with the accumulator seeded by the first active element.
- R2: Operation codes 5, 6 and 7 are refused: `done` and `rej` rise together in the cycle after the start edge, and nothing is written to the element array or the condition field.
- R3: An element is active only when its index is below `vl` and its predicate bit is set; inactive elements are never read or written, and every element other than the destination keeps its value.
- R4: With at least one active element, the scalar result is written exactly once, to the lowest-indexed active element, in the cycle in which `done` is high.
- R5: With exactly one active element, that element is written back to itself unchanged.
- R6: With no active element, `done` rises and neither the element array nor the condition field is written.
- R7: The condition field is 3 bits: bit 2 set when the signed partial result is negative, bit 1 when it is positive, bit 0 when it is zero; with a single active element it is that element's own classification.
- R8: With `rc`=1 and `crm`=0, the field written is the OR of the classifications of every partial result; with `rc`=0, no condition field is written.
- R9: With `rc`=1 and `crm`=1, the field written is the AND of the classifications of every partial result.
- R10: `elem_off` is 0 after reset, takes the index of each element as it is consumed, and holds its value across rejected and empty runs.
- R11: `done` is a one-cycle pulse; counted from the start edge, it is high in cycle max(k,1)+1 for k active elements and in cycle 1 for a refused operation.
- R12: A `start` pulse arriving while a reduction is in progress is ignored and does not disturb the reduction in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction; sampled only while idle |
| vl | input | IW+1 | Vector length, 0 to 2^(IW+1)-1; lanes at or above it are inactive |
| pred | input | N | Predicate mask, one bit per element |
| op | input | 3 | Operation code |
| rc | input | 1 | Enable condition-field write |
| crm | input | 1 | Condition merge: 0 = OR (some), 1 = AND (all) |
| rd_en | output | 1 | Element read strobe |
| rd_idx | output | IW | Element read index |
| rd_data | input | DW | Element read data, same cycle |
| wr_en | output | 1 | Element write strobe |
| wr_idx | output | IW | Element write index |
| wr_data | output | DW | Element write data |
| cr_we | output | 1 | Condition field write strobe |
| cr_val | output | 3 | Condition field value {neg, pos, zero} |
| elem_off | output | IW | Saved element offset |
| done | output | 1 | One-cycle completion pulse |
| rej | output | 1 | Qualifies `done`: operation refused |

## Verification
The hardest situations to reach from the ports are a predicate with holes, where the walk must hop over gaps while reading ahead, and an AND merge that has to collapse to an empty field part-way through a walk. The bench sweeps every 8-bit mask under each legal operation and both merge modes, with small signed data that straddles zero, so sign changes, zero partials and multiply wrap all appear. A second `start` is also injected in the first busy cycle of some runs to show it is ignored.

// File: rtl/red_pkg.sv
package red_pkg;

  localparam int OPW = 3;

  localparam logic [OPW-1:0] OP_ADD = 3'd0;
  localparam logic [OPW-1:0] OP_MUL = 3'd1;
  localparam logic [OPW-1:0] OP_MIN = 3'd2;
  localparam logic [OPW-1:0] OP_MAX = 3'd3;
  localparam logic [OPW-1:0] OP_OR  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_STEP = 2'd2,
    ST_FIN  = 2'd3
  } red_state_e;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zro;
  } cond_t;

  function automatic logic op_legal(input logic [OPW-1:0] code);
    return code <= OP_OR;
  endfunction

endpackage

// File: rtl/red_scan.sv
module red_scan #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0] mask,
  input  logic [IW:0]  from,
  output logic         found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && ((IW+1)'(i) >= from)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/red_alu.sv
module red_alu
  import red_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  output logic [DW-1:0]  y
);
  logic a_lt_b;

  assign a_lt_b = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_MUL:  y = a * b;
      OP_MIN:  y = a_lt_b ? a : b;
      OP_MAX:  y = a_lt_b ? b : a;
      OP_OR:   y = a | b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/red_cond.sv
module red_cond
  import red_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] val,
  input  cond_t         prev,
  input  logic          seed,
  input  logic          crm,
  output cond_t         merged
);
  cond_t cur;

  always_comb begin
    cur.neg = val[DW-1];
    cur.zro = (val == '0);
    cur.pos = !val[DW-1] && (val != '0);
    if (seed)
      merged = cur;
    else if (crm)
      merged = prev & cur;
    else
      merged = prev | cur;
  end
endmodule

// File: rtl/red_seq.sv
module red_seq
  import red_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW:0]    vl,
  input  logic [N-1:0]   pred,
  input  logic [2:0]     op,
  input  logic           rc,
  input  logic           crm,
  output logic           rd_en,
  output logic [IW-1:0]  rd_idx,
  input  logic [DW-1:0]  rd_data,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [DW-1:0]  wr_data,
  output logic           cr_we,
  output logic [2:0]     cr_val,
  output logic [IW-1:0]  elem_off,
  output logic           done,
  output logic           rej
);
  red_state_e     st_q;
  logic [N-1:0]   act_q;
  logic [2:0]     op_q;
  logic           rc_q, crm_q, rej_q, have_q;
  logic [IW-1:0]  cur_q, dst_q, off_q;
  logic [DW-1:0]  acc_q;
  cond_t          cr_q;

  logic [N-1:0]   lane_in;
  logic           first_ok, next_ok;
  logic [IW-1:0]  first_idx, next_idx, cur_idx;
  logic [IW:0]    next_from;
  logic           seeking, consume;
  logic [DW-1:0]  fold_y, new_val;
  cond_t          cr_new;

  generate
    for (genvar g = 0; g < N; g++) begin : g_lane
      assign lane_in[g] = pred[g] && (vl > (IW+1)'(g));
    end
  endgenerate

  assign seeking   = (st_q == ST_SEEK);
  assign cur_idx   = seeking ? first_idx : cur_q;
  assign consume   = (seeking && first_ok) || (st_q == ST_STEP);
  assign next_from = {1'b0, cur_idx} + (IW+1)'(1);

  red_scan #(.N(N), .IW(IW)) u_scan_first (
    .mask (act_q),
    .from ('0),
    .found(first_ok),
    .idx  (first_idx)
  );

  red_scan #(.N(N), .IW(IW)) u_scan_next (
    .mask (act_q),
    .from (next_from),
    .found(next_ok),
    .idx  (next_idx)
  );

  red_alu #(.DW(DW)) u_alu (
    .op(op_q),
    .a (acc_q),
    .b (rd_data),
    .y (fold_y)
  );

  assign new_val = seeking ? rd_data : fold_y;

  red_cond #(.DW(DW)) u_cond (
    .val   (new_val),
    .prev  (cr_q),
    .seed  (seeking),
    .crm   (crm_q),
    .merged(cr_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_q  <= '0;
      op_q   <= '0;
      rc_q   <= 1'b0;
      crm_q  <= 1'b0;
      rej_q  <= 1'b0;
      have_q <= 1'b0;
      cur_q  <= '0;
      dst_q  <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      cr_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            act_q  <= lane_in;
            op_q   <= op;
            rc_q   <= rc;
            crm_q  <= crm;
            rej_q  <= !op_legal(op);
            have_q <= 1'b0;
            st_q   <= op_legal(op) ? ST_SEEK : ST_FIN;
          end
        end
        ST_SEEK, ST_STEP: begin
          if (consume) begin
            acc_q <= new_val;
            cr_q  <= cr_new;
            off_q <= cur_idx;
            if (seeking) begin
              dst_q  <= cur_idx;
              have_q <= 1'b1;
            end
            if (next_ok) begin
              cur_q <= next_idx;
              st_q  <= ST_STEP;
            end else begin
              st_q  <= ST_FIN;
            end
          end else begin
            st_q <= ST_FIN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en    = consume;
  assign rd_idx   = cur_idx;
  assign done     = (st_q == ST_FIN);
  assign rej      = done && rej_q;
  assign wr_en    = done && have_q && !rej_q;
  assign wr_idx   = dst_q;
  assign wr_data  = acc_q;
  assign cr_we    = wr_en && rc_q;
  assign cr_val   = cr_q;
  assign elem_off = off_q;

endmodule

// File: rtl/red_seq_chk.sv
module red_seq_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [IW:0]   vl,
  input logic [N-1:0]  pred,
  input logic          rc,
  input logic          crm,
  input logic          rd_en,
  input logic [IW-1:0] rd_idx,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          cr_we,
  input logic [2:0]    cr_val,
  input logic          done,
  input logic          rej
);
  logic          busy_c, rc_c, crm_c;
  logic [N-1:0]  act_c, live;

  always_comb begin
    for (int i = 0; i < N; i++) live[i] = pred[i] && (int'(vl) > i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      act_c  <= '0;
      rc_c   <= 1'b0;
      crm_c  <= 1'b0;
    end else if (start && !busy_c) begin
      busy_c <= 1'b1;
      act_c  <= live;
      rc_c   <= rc;
      crm_c  <= crm;
    end else if (done) begin
      busy_c <= 1'b0;
    end
  end

  p_read_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> act_c[rd_idx]);

  p_write_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && act_c[wr_idx]));

  p_refused_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rej) |-> (!wr_en && !cr_we));

  p_cr_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> (wr_en && rc_c));

  p_all_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_we && crm_c) |-> $onehot0(cr_val));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_noread_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_c |-> !rd_en);

endmodule

bind red_seq red_seq_chk #(.N(N), .IW(IW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .vl    (vl),
  .pred  (pred),
  .rc    (rc),
  .crm   (crm),
  .rd_en (rd_en),
  .rd_idx(rd_idx),
  .wr_en (wr_en),
  .wr_idx(wr_idx),
  .cr_we (cr_we),
  .cr_val(cr_val),
  .done  (done),
  .rej   (rej)
);

// File: tb/red_seq_tb.sv
`timescale 1ns/1ps
module red_seq_tb;
  localparam int N  = 8;
  localparam int DW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW:0]   vl = '0;
  logic [N-1:0]  pred = '0;
  logic [2:0]    op = '0;
  logic          rc = 1'b0, crm = 1'b0;
  logic          rd_en, wr_en, cr_we, done, rej;
  logic [IW-1:0] rd_idx, wr_idx, elem_off;
  logic [DW-1:0] rd_data, wr_data;
  logic [2:0]    cr_val;

  logic [DW-1:0] mem [N];
  logic [2:0]    crcap;
  int            wcnt, ccnt;
  int            n_chk = 0, n_fail = 0, rn = 0, exp_off = 0;

  always #2.5 clk = ~clk;

  red_seq #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
    .op(op), .rc(rc), .crm(crm), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cr_we(cr_we), .cr_val(cr_val), .elem_off(elem_off), .done(done),
    .rej(rej)
  );

  assign rd_data = mem[rd_idx];

  always @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
      wcnt = wcnt + 1;
    end
    if (cr_we) begin
      crcap <= cr_val;
      ccnt = ccnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] fop(input int code, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (code)
      0: return a + b;
      1: return a * b;
      2: return ($signed(a) < $signed(b)) ? a : b;
      3: return ($signed(a) < $signed(b)) ? b : a;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [2:0] cls(input logic [DW-1:0] v);
    return {$signed(v) < 0, $signed(v) > 0, v == '0};
  endfunction

  task automatic run(input int opv, input int vlv, input int pm,
                     input bit rcv, input bit crmv, input bit poke);
    logic [DW-1:0] e [N];
    logic [DW-1:0] acc;
    logic [2:0]    cr, c;
    int            k, dst, last, lat, exp_lat;
    bit            legal;
    string         tag;
    rn++;
    for (int i = 0; i < N; i++) begin
      mem[i] = DW'(((rn * 7 + i * 5 + (rn >> 2)) % 16) - 8);
      e[i]   = mem[i];
    end
    legal = (opv <= 4);
    k = 0; dst = 0; last = 0; acc = '0; cr = '0;
    for (int i = 0; i < N; i++) begin
      if (i < vlv && pm[i]) begin
        if (k == 0) begin
          acc = mem[i]; cr = cls(acc); dst = i;
        end else begin
          acc = fop(opv, acc, mem[i]);
          c   = cls(acc);
          cr  = crmv ? (cr & c) : (cr | c);
        end
        last = i;
        k++;
      end
    end
    if (legal && k > 0) e[dst] = acc;
    wcnt = 0; ccnt = 0; crcap = '0;
    vl = (IW+1)'(vlv); pred = N'(pm); op = 3'(opv); rc = rcv; crm = crmv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (poke && lat == 1) begin
        start = 1'b1; op = 3'd1; pred = '1; vl = (IW+1)'(N);
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    exp_lat = !legal ? 1 : ((k > 1) ? k + 1 : 2);
    chk(done == 1'b1, "R11 done seen", int'(done), 1);
    chk(lat == exp_lat, poke ? "R12 latency with busy start" : "R11 latency", lat, exp_lat);
    chk(rej == !legal, "R2 rej flag", int'(rej), int'(!legal));
    @(negedge clk);
    tag = (!legal) ? "R2 writes" : ((k == 0) ? "R6 writes" : "R4 writes");
    chk(wcnt == int'(legal && k > 0), tag, wcnt, int'(legal && k > 0));
    chk(ccnt == int'(legal && k > 0 && rcv), "R8 cond write count", ccnt, int'(legal && k > 0 && rcv));
    if (legal && k > 0 && rcv) begin
      tag = (k == 1) ? "R7 cond single" : (crmv ? "R9 cond all" : "R8 cond some");
      chk(crcap == cr, tag, int'(crcap), int'(cr));
    end
    for (int i = 0; i < N; i++) begin
      if (legal && k > 0 && i == dst)
        tag = (k == 1) ? "R5 single copy" : (poke ? "R12 result" : "R1 result");
      else
        tag = "R3 untouched element";
      chk(mem[i] == e[i], tag, int'($signed(mem[i])), int'($signed(e[i])));
    end
    if (legal && k > 0) exp_off = last;
    chk(int'(elem_off) == exp_off, "R10 offset", int'(elem_off), exp_off);
    chk(done == 1'b0, "R11 pulse", int'(done), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && wr_en == 1'b0, "R11 reset done", int'(done), 0);
    chk(cr_we == 1'b0 && rd_en == 1'b0, "R8 reset cond", int'(cr_we), 0);
    chk(elem_off == '0, "R10 reset offset", int'(elem_off), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 5; o++)
      for (int m = 0; m < 256; m++)
        for (int cm = 0; cm < 2; cm++)
          run(o, 8, m, 1'b1, cm[0], (m % 17) == 3);
    for (int v = 0; v < 16; v++) begin
      run(0, v, 8'hff, 1'b1, 1'b0, 1'b0);
      run(3, v, 8'h5a, 1'b1, 1'b1, 1'b0);
    end
    for (int m = 0; m < 256; m += 37) run(2, 8, m, 1'b0, 1'b0, 1'b0);
    for (int o = 5; o < 8; o++) begin
      run(o, 8, 8'hff, 1'b1, 1'b0, 1'b0);
      run(o, 8, 8'h00, 1'b1, 1'b1, 1'b0);
      run(o, 5, 8'h24, 1'b1, 1'b0, 1'b0);
    end
    summary();
  end
endmodule